// File: doc/BRIEF.md
# Embedded Operations Channel Responder

This block serves the 8-bit maintenance message carried in the overhead bits of a basic-rate digital subscriber line. Each received message arrives with a strobe. The block accepts a message only after the same value has arrived in two consecutive frames, so that a single corrupted frame does not count. Each accepted change is decoded into one of eight defined commands: three loopback variants, a request to corrupt the transmitted CRC, a notice that the CRC was corrupted, return to normal, hold, and unable to comply.

In automatic mode the block drives the loopback and CRC-corrupt controls itself. It answers each accepted command by echoing it, and answers any unknown code with the unable-to-comply pattern. In manual mode the controls keep their values. A processor reads the accepted message in two halves, decides what to do, and writes the reply in two halves. A change of the accepted message sets a sticky status bit in either mode. When that status is unmasked, it drives a summary bit and the interrupt pin, so the processor can complete its service within the 1.5 ms budget.

Top module: `eoc_responder`

## Requirements
- R1: After reset, tx_msg is 0xFF, loop_b1, loop_b2, loop_d and crc_corrupt are 0, irq is 0, and the control register (address 0) reads 0x03. Bit 0 is the automatic-mode enable and bit 1 is the interrupt mask, where 1 means masked.
- R2: A received value is accepted only when it equals the value strobed in the frame just before it and differs from the currently accepted message. A value that arrives in one frame only changes nothing. rx_msg[7] carries overhead message bit 1 and rx_msg[0] carries bit 8.
- R3: In automatic mode, accepting 0x50 sets loop_b1, loop_b2 and loop_d. Accepting 0x51 sets loop_b1 alone, and accepting 0x52 sets loop_b2 alone. Each of these codes is echoed on tx_msg.
- R4: In automatic mode, accepting 0x53 sets crc_corrupt and leaves the loopbacks unchanged. Accepting 0x54 changes no control. Both codes are echoed on tx_msg.
- R5: In automatic mode, accepting 0x00 (hold) leaves tx_msg and all controls unchanged.
- R6: In automatic mode, accepting any undefined code drives tx_msg to 0xAA and leaves all controls unchanged.
- R7: In automatic mode, accepting 0xFF clears every loopback and crc_corrupt on the clock edge after acceptance, and drives tx_msg to 0xFF.
- R8: Every accepted change, in either mode, sets a sticky change flag, which reads as bit 0 of the status register (address 1).
- R9: irq and bit 0 of the summary register (address 2) are high exactly when the change flag is set and the interrupt mask is 0.
- R10: Writing a 1 to status bit 0 clears the change flag, and irq then falls. Writing a 0 leaves the flag unchanged.
- R11: With control bit 0 cleared, tx_msg is {TXH[3:0], TXL[3:0]}, where TXH is address 5 and TXL is address 6. Both registers reset to 0xF.
- R12: In manual mode, the accepted message reads as its upper nibble at address 3 and its lower nibble at address 4, in data bits 3:0. Accepted commands leave the loopback and CRC controls unchanged.
- R13: When a change is accepted in the same cycle as a write that clears the flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe per received frame |
| rx_msg | input | 8 | Received overhead message, bit 7 = message bit 1 |
| tx_msg | output | 8 | Message to transmit |
| loop_b1 | output | 1 | B1 channel loopback enable |
| loop_b2 | output | 1 | B2 channel loopback enable |
| loop_d | output | 1 | D channel loopback enable |
| crc_corrupt | output | 1 | Corrupt the transmitted CRC |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt, active high |

## Verification
Acceptance of a new message, which sets the sticky change flag, can fall in the same clock cycle as a processor write that clears that flag. The bench provokes this by sending a code once and then strobing the confirming frame. On the next cycle it issues the clear write, so that the clear arrives on the very edge where the flag is being set. It then judges the outcome by reading the status register and irq: the flag must still be set, and a later plain clear must remove it.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
  localparam int MSG_W  = 8;
  localparam int NIB_W  = MSG_W / 2;
  localparam int ADDR_W = 3;
  localparam int CTL_W  = 4;

  localparam logic [MSG_W-1:0] C_LOOP_ALL = 8'h50;
  localparam logic [MSG_W-1:0] C_LOOP_B1  = 8'h51;
  localparam logic [MSG_W-1:0] C_LOOP_B2  = 8'h52;
  localparam logic [MSG_W-1:0] C_CRC_REQ  = 8'h53;
  localparam logic [MSG_W-1:0] C_CRC_NOTE = 8'h54;
  localparam logic [MSG_W-1:0] C_NORMAL   = 8'hFF;
  localparam logic [MSG_W-1:0] C_HOLD     = 8'h00;
  localparam logic [MSG_W-1:0] C_NOCOMPLY = 8'hAA;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_SUM  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXH  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TXH  = 3'd5;
  localparam logic [ADDR_W-1:0] A_TXL  = 3'd6;

  // control vector bit positions
  localparam int K_B1  = 0;
  localparam int K_B2  = 1;
  localparam int K_D   = 2;
  localparam int K_CRC = 3;
endpackage

// File: rtl/eoc_rx_filter.sv
module eoc_rx_filter
  import eoc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [MSG_W-1:0] rx_msg,
  output logic [MSG_W-1:0] acc_msg,
  output logic             acc_chg
);
  logic [MSG_W-1:0] raw_q, raw_d, acc_q, acc_d;
  logic             chg_q, chg_d;

  always_comb begin
    raw_d = raw_q;
    acc_d = acc_q;
    chg_d = 1'b0;
    if (rx_valid) begin
      raw_d = rx_msg;
      if ((rx_msg == raw_q) && (rx_msg != acc_q)) begin
        acc_d = rx_msg;
        chg_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= C_NORMAL;
      acc_q <= C_NORMAL;
      chg_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      acc_q <= acc_d;
      chg_q <= chg_d;
    end
  end

  assign acc_msg = acc_q;
  assign acc_chg = chg_q;

  // R2
  chg_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_chg |-> $past(rx_valid));
  // R2
  chg_is_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_chg |-> (acc_msg != $past(acc_msg)));
endmodule

// File: rtl/eoc_auto_resp.sv
module eoc_auto_resp
  import eoc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             acc_chg,
  input  logic [MSG_W-1:0] acc_msg,
  output logic [CTL_W-1:0] ctl,
  output logic [MSG_W-1:0] tx_auto
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [MSG_W-1:0] tx_q, tx_d;
  logic             upd_en;

  assign upd_en = auto_en && acc_chg;

  always_comb begin
    ctl_d = ctl_q;
    tx_d  = tx_q;
    if (upd_en) begin
      unique case (acc_msg)
        C_LOOP_ALL: begin
          ctl_d[K_B1] = 1'b1; ctl_d[K_B2] = 1'b1; ctl_d[K_D] = 1'b1;
          tx_d = acc_msg;
        end
        C_LOOP_B1: begin
          ctl_d[K_B1] = 1'b1; ctl_d[K_B2] = 1'b0; ctl_d[K_D] = 1'b0;
          tx_d = acc_msg;
        end
        C_LOOP_B2: begin
          ctl_d[K_B1] = 1'b0; ctl_d[K_B2] = 1'b1; ctl_d[K_D] = 1'b0;
          tx_d = acc_msg;
        end
        C_CRC_REQ: begin
          ctl_d[K_CRC] = 1'b1;
          tx_d = acc_msg;
        end
        C_CRC_NOTE: tx_d = acc_msg;
        C_NORMAL: begin
          ctl_d = '0;
          tx_d  = C_NORMAL;
        end
        C_HOLD: ;
        default: tx_d = C_NOCOMPLY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      tx_q  <= C_NORMAL;
    end else if (upd_en) begin
      ctl_q <= ctl_d;
      tx_q  <= tx_d;
    end
  end

  assign ctl     = ctl_q;
  assign tx_auto = tx_q;

  // R7
  normal_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && acc_msg == C_NORMAL) |=> (ctl == '0));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && acc_msg == C_HOLD) |=> ($stable(ctl) && $stable(tx_auto)));
  // R12
  manual_keeps_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en) |=> $stable(ctl));
endmodule

// File: rtl/eoc_regs.sv
module eoc_regs
  import eoc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [MSG_W-1:0]  reg_wdata,
  output logic [MSG_W-1:0]  reg_rdata,
  input  logic              acc_chg,
  input  logic [MSG_W-1:0]  acc_msg,
  output logic              auto_en,
  output logic [MSG_W-1:0]  man_tx,
  output logic              irq
);
  logic [1:0]       ctrl_q, ctrl_d;
  logic             stk_q, stk_d;
  logic [NIB_W-1:0] txh_q, txh_d, txl_q, txl_d;
  logic             wr_ctrl, wr_stat, wr_txh, wr_txl;
  logic             irq_sum;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_txh  = reg_wr && (reg_addr == A_TXH);
  assign wr_txl  = reg_wr && (reg_addr == A_TXL);

  always_comb begin
    ctrl_d = ctrl_q;
    txh_d  = txh_q;
    txl_d  = txl_q;
    stk_d  = stk_q;
    if (wr_ctrl) ctrl_d = reg_wdata[1:0];
    if (wr_txh)  txh_d  = reg_wdata[NIB_W-1:0];
    if (wr_txl)  txl_d  = reg_wdata[NIB_W-1:0];
    if (wr_stat && reg_wdata[0]) stk_d = 1'b0;
    if (acc_chg) stk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 2'b11;
      stk_q  <= 1'b0;
      txh_q  <= '1;
      txl_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      stk_q  <= stk_d;
      txh_q  <= txh_d;
      txl_q  <= txl_d;
    end
  end

  assign irq_sum = stk_q && !ctrl_q[1];
  assign irq     = irq_sum;
  assign auto_en = ctrl_q[0];
  assign man_tx  = {txh_q, txl_q};

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: reg_rdata = {6'b0, ctrl_q};
      A_STAT: reg_rdata = {7'b0, stk_q};
      A_SUM:  reg_rdata = {7'b0, irq_sum};
      A_RXH:  reg_rdata = {{NIB_W{1'b0}}, acc_msg[MSG_W-1:NIB_W]};
      A_RXL:  reg_rdata = {{NIB_W{1'b0}}, acc_msg[NIB_W-1:0]};
      A_TXH:  reg_rdata = {{NIB_W{1'b0}}, txh_q};
      A_TXL:  reg_rdata = {{NIB_W{1'b0}}, txl_q};
      default: reg_rdata = '0;
    endcase
  end

  // R8, R13
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_chg |=> irq_sum || ctrl_q[1]);
  // R10
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[0] && !acc_chg) |=> !irq);
endmodule

// File: rtl/eoc_responder.sv
module eoc_responder
  import eoc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [MSG_W-1:0]  rx_msg,
  output logic [MSG_W-1:0]  tx_msg,
  output logic              loop_b1,
  output logic              loop_b2,
  output logic              loop_d,
  output logic              crc_corrupt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [MSG_W-1:0]  reg_wdata,
  output logic [MSG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [MSG_W-1:0] acc_msg, tx_auto, man_tx;
  logic             acc_chg, auto_en;
  logic [CTL_W-1:0] ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eoc_rx_filter i_filter (
    .clk(clk), .rst_n(rst_int_n), .rx_valid(rx_valid), .rx_msg(rx_msg),
    .acc_msg(acc_msg), .acc_chg(acc_chg));

  eoc_auto_resp i_auto (
    .clk(clk), .rst_n(rst_int_n), .auto_en(auto_en), .acc_chg(acc_chg),
    .acc_msg(acc_msg), .ctl(ctl), .tx_auto(tx_auto));

  eoc_regs i_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_chg(acc_chg),
    .acc_msg(acc_msg), .auto_en(auto_en), .man_tx(man_tx), .irq(irq));

  assign tx_msg      = auto_en ? tx_auto : man_tx;
  assign loop_b1     = ctl[K_B1];
  assign loop_b2     = ctl[K_B2];
  assign loop_d      = ctl[K_D];
  assign crc_corrupt = ctl[K_CRC];

  // R11
  manual_tx_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!auto_en && $stable(man_tx) && $past(!auto_en)) |-> $stable(tx_msg));
endmodule

// File: tb/test_eoc_responder.sv
`timescale 1ns/1ps
module test_eoc_responder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid;
  logic [7:0] rx_msg;
  logic [7:0] tx_msg;
  logic       loop_b1, loop_b2, loop_d, crc_corrupt;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  typedef struct {
    string       req;
    bit          is_reg;
    logic [12:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eoc_responder i_eoc_responder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_msg(rx_msg),
    .tx_msg(tx_msg), .loop_b1(loop_b1), .loop_b2(loop_b2), .loop_d(loop_d),
    .crc_corrupt(crc_corrupt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [12:0] pk(input logic i, input logic c, input logic d,
                                     input logic b2, input logic b1, input logic [7:0] t);
    return {i, c, d, b2, b1, t};
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [12:0] act;
      wait (q.size() > 0);
      #1;
      it = q.pop_front();
      act = it.is_reg ? {5'b0, reg_rdata} :
            {irq, crc_corrupt, loop_d, loop_b2, loop_b1, tx_msg};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_out(input string req, input logic [12:0] e);
    item_t it;
    it.req = req; it.is_reg = 1'b0; it.exp = e;
    q.push_back(it);
    wait (q.size() == 0);
    #2;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] e);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.req = req; it.is_reg = 1'b1; it.exp = {5'b0, e};
    q.push_back(it);
    wait (q.size() == 0);
    #2;
  endtask

  task automatic frame(input logic [7:0] m);
    @(negedge clk);
    rx_valid = 1'b1; rx_msg = m;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] m);
    frame(m);
    frame(m);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_msg = 8'h00;
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    expect_out("R1 reset outputs", pk(0,0,0,0,0,8'hFF));
    expect_reg("R1 ctrl reset", 3'd0, 8'h03);

    frame(8'h50); frame(8'h00); @(negedge clk);
    expect_out("R2 single frames ignored", pk(0,0,0,0,0,8'hFF));

    cmd(8'h50); expect_out("R3 loop all", pk(0,0,1,1,1,8'h50));
    cmd(8'h51); expect_out("R3 loop b1", pk(0,0,0,0,1,8'h51));
    cmd(8'h52); expect_out("R3 loop b2", pk(0,0,0,1,0,8'h52));
    cmd(8'h53); expect_out("R4 crc request", pk(0,1,0,1,0,8'h53));
    cmd(8'h54); expect_out("R4 crc notice", pk(0,1,0,1,0,8'h54));
    cmd(8'h00); expect_out("R5 hold", pk(0,1,0,1,0,8'h54));
    cmd(8'h3C); expect_out("R6 unknown code", pk(0,1,0,1,0,8'hAA));
    cmd(8'hFF); expect_out("R7 return to normal", pk(0,0,0,0,0,8'hFF));

    expect_reg("R8 sticky set", 3'd1, 8'h01);
    wr(3'd0, 8'h01);
    expect_out("R9 irq unmasked", pk(1,0,0,0,0,8'hFF));
    expect_reg("R9 summary bit", 3'd2, 8'h01);
    wr(3'd1, 8'h00);
    expect_reg("R10 write zero keeps flag", 3'd1, 8'h01);
    wr(3'd1, 8'h01);
    expect_out("R10 irq cleared", pk(0,0,0,0,0,8'hFF));
    expect_reg("R10 flag cleared", 3'd1, 8'h00);

    cmd(8'h50);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h00);
    expect_out("R11 manual reset reply", pk(0,0,1,1,1,8'hFF));
    wr(3'd5, 8'h05);
    wr(3'd6, 8'h0A);
    expect_out("R11 manual reply", pk(0,0,1,1,1,8'h5A));

    cmd(8'h51);
    expect_out("R12 manual controls kept", pk(1,0,1,1,1,8'h5A));
    expect_reg("R12 rx high nibble", 3'd3, 8'h05);
    expect_reg("R12 rx low nibble", 3'd4, 8'h01);
    wr(3'd1, 8'h01);
    expect_reg("R10 cleared in manual", 3'd1, 8'h00);

    // collision: clear write lands on the edge that sets the flag
    frame(8'h52);
    @(negedge clk);
    rx_valid = 1'b1; rx_msg = 8'h52;
    @(negedge clk);
    rx_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0;
    expect_reg("R13 set beats clear", 3'd1, 8'h01);
    expect_out("R13 irq held", pk(1,0,1,1,1,8'h5A));
    wr(3'd1, 8'h01);
    expect_reg("R13 later clear works", 3'd1, 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule